// File: doc/BRIEF.md
# Audio Service FIFO with Attention Threshold

This block is a single-clock sample FIFO placed between a bus or DMA side and an audio serial engine. One copy, built with `IS_PLAYBACK = 1`, carries samples from the bus to the serial engine. A second copy, built with `IS_PLAYBACK = 0`, carries samples from the serial engine back to the bus. Each entry is 32 bits wide. The FIFO is 16 entries deep.

The block reports a slot count for servicing. In playback this count is the number of free slots. In capture it is the number of filled slots. An attention output asks for service once that count reaches a threshold chosen by a 2-bit code. The block also gives ready, busy and sticky error flags, a one-cycle flush and a serial-side enable. In packed mode each entry holds two 16-bit samples, and the serial engine moves them one half at a time.

Top module: `audio_svc_fifo`

## Requirements
- R1: After reset the FIFO is empty. Playback shows slot_count 16, ready 1 and attn 1 (with lvl_code 0). Capture shows slot_count 0, ready 0 and attn 0. Both show busy 0, error 0 and zero on the data outputs.
- R2: Entries leave in the order they arrived. At most 16 are held, and a bus-side write to a full playback FIFO or a bus-side read of an empty capture FIFO is dropped without effect.
- R3: slot_count equals 16 minus the stored entries in playback, and the stored entries in capture. Its range is 0 to 16.
- R4: attn is 1 exactly when slot_count is at least the threshold selected by lvl_code. The codes are 0 for 1 slot, 1 for 4 slots, 2 for 8 slots and 3 for 12 slots.
- R5: ready is 1 when the bus side can act: playback holds fewer than 16 entries, or capture holds at least one entry.
- R6: busy is 1 exactly when enable is 1 and the FIFO holds at least one entry.
- R7: While enable is 0, ser_req has no effect. Nothing is pushed or popped, packing does not advance and no error is raised.
- R8: error becomes 1 in two cases. In playback, an enabled ser_req arrives while the FIFO is empty. In capture, an enabled ser_req completes an entry while the FIFO holds 16, and that word is dropped. Once set, error stays 1 until it is cleared.
- R9: err_w1c high for one cycle clears error. If an error event happens in the same cycle, the event wins and error stays 1.
- R10: clear high empties the FIFO in one cycle and resets the packing half. It overrides any push, pop or serial request in that cycle and does not change error.
- R11: In packed playback, each entry gives two serial samples on ser_rdata, zero-extended: bits 15:0 first, then bits 31:16. The entry is freed on the second request.
- R12: In packed capture, the first serial sample (ser_wdata bits 15:0) becomes entry bits 15:0. The second becomes bits 31:16. The entry is stored on the second request.
- R13: The output that shows the head entry reads zero while the FIFO is empty. This is ser_rdata in playback and bus_rd_data in capture.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Lets the serial side transfer |
| clear | input | 1 | One-cycle flush |
| packed_mode | input | 1 | Two 16-bit samples per entry on the serial side |
| lvl_code | input | 2 | Attention threshold code |
| err_w1c | input | 1 | Clears the sticky error flag |
| bus_wr_en | input | 1 | Bus-side push (playback copy) |
| bus_wr_data | input | 32 | Bus-side push data |
| bus_rd_en | input | 1 | Bus-side pop (capture copy) |
| bus_rd_data | output | 32 | Head entry for the bus (capture copy) |
| ser_req | input | 1 | Serial-side transfer request |
| ser_wdata | input | 32 | Serial-side sample in (capture copy) |
| ser_rdata | output | 32 | Serial-side sample out (playback copy) |
| slot_count | output | 6 | Free slots (playback) or filled slots (capture) |
| attn | output | 1 | Service request at threshold |
| ready | output | 1 | Bus side may act |
| busy | output | 1 | Enabled and holding data |
| error | output | 1 | Sticky underrun or overrun flag |

## Verification
Two pairs of functions can fall in the same cycle. The first pair is the flush and a transfer: clear is asserted together with a bus write, an enabled serial request and a bus read. The check expects the count to return to its empty value, no push to land and error to keep its value. The second pair is the error flag's set and clear: err_w1c is pulsed while the playback FIFO is empty and a serial request is pending. The check expects error to stay 1, and expects it to fall only after a later err_w1c with no error event in that cycle. Random traffic with a fixed seed adds many more such overlaps, and a queue-based model in the bench judges each one.

// File: rtl/audio_fifo_pkg.sv
// Shared constants for the audio service FIFO.
// Assumes: the attention threshold is chosen by a 2-bit code.
package audio_fifo_pkg;
    localparam int ATTN_CODE_W = 2;

    typedef enum logic [ATTN_CODE_W-1:0] {
        ATTN_ONE    = 2'd0,
        ATTN_FOUR   = 2'd1,
        ATTN_EIGHT  = 2'd2,
        ATTN_TWELVE = 2'd3
    } attn_code_e;

    localparam int SLOTS_ONE    = 1;
    localparam int SLOTS_FOUR   = 4;
    localparam int SLOTS_EIGHT  = 8;
    localparam int SLOTS_TWELVE = 12;
endpackage

// File: rtl/afifo_store.sv
// Storage ring for the audio service FIFO: memory, read and write pointers
// and a fill counter.
// Assumes: the caller never pushes when full or pops when empty, and gates
// both with clear. Clear returns the pointers and the fill to zero in one cycle.
module afifo_store #(
    parameter int WIDTH = 32,
    parameter int DEPTH = 16
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         clear,
    input  logic                         push,
    input  logic [WIDTH-1:0]             push_data,
    input  logic                         pop,
    output logic [WIDTH-1:0]             head_data,
    output logic [$clog2(DEPTH+1)-1:0]   fill,
    output logic                         empty,
    output logic                         full
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int FW = $clog2(DEPTH + 1);

    logic [WIDTH-1:0] mem [DEPTH];
    logic [AW-1:0]    wr_ptr;
    logic [AW-1:0]    rd_ptr;
    logic [FW-1:0]    fill_q;

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // Write the pushed word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push) begin
            mem[wr_ptr] <= push_data;
        end
    end

    // Advance the pointers and track the fill level.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill_q <= '0;
        end else begin
            if (push) wr_ptr <= bump(wr_ptr);
            if (pop)  rd_ptr <= bump(rd_ptr);
            case ({push, pop})
                2'b10:   fill_q <= fill_q + 1'b1;
                2'b01:   fill_q <= fill_q - 1'b1;
                default: fill_q <= fill_q;
            endcase
        end
    end

    assign head_data = mem[rd_ptr];
    assign fill      = fill_q;
    assign empty     = (fill_q == '0);
    assign full      = (fill_q == FW'(DEPTH));
endmodule

// File: rtl/afifo_halfsel.sv
// Serial-side packing for the audio service FIFO. It tracks which 16-bit
// half of an entry is next, shapes the outgoing serial sample and assembles
// the incoming word from two samples.
// Assumes: WIDTH is even. step is one accepted serial transfer.
module afifo_halfsel #(
    parameter int WIDTH = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             packed_mode,
    input  logic             step,
    input  logic [WIDTH-1:0] ser_wdata,
    input  logic [WIDTH-1:0] head_data,
    input  logic             empty,
    output logic             boundary,
    output logic [WIDTH-1:0] rd_sample,
    output logic [WIDTH-1:0] wr_word
);
    localparam int HALF_W = WIDTH / 2;

    logic              half_q;
    logic [HALF_W-1:0] stage_q;

    // Toggle the half pointer and hold the first sample of a packed pair.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) begin
            half_q  <= 1'b0;
            stage_q <= '0;
        end else if (step) begin
            half_q <= packed_mode & ~half_q;
            if (packed_mode && !half_q) begin
                stage_q <= ser_wdata[HALF_W-1:0];
            end
        end
    end

    assign boundary = ~packed_mode | half_q;

    // Select the serial sample shown from the head entry.
    always_comb begin
        if (empty) begin
            rd_sample = '0;
        end else if (!packed_mode) begin
            rd_sample = head_data;
        end else if (half_q) begin
            rd_sample = {{(WIDTH-HALF_W){1'b0}}, head_data[WIDTH-1:HALF_W]};
        end else begin
            rd_sample = {{(WIDTH-HALF_W){1'b0}}, head_data[HALF_W-1:0]};
        end
    end

    assign wr_word = packed_mode ? {ser_wdata[HALF_W-1:0], stage_q} : ser_wdata;
endmodule

// File: rtl/afifo_status.sv
// Status for the audio service FIFO: the service slot count, the attention
// threshold compare, ready, busy and the sticky error flag.
// Assumes: COUNT_W is wide enough to hold DEPTH. An error event wins over
// err_w1c in the same cycle.
module afifo_status
    import audio_fifo_pkg::*;
#(
    parameter bit IS_PLAYBACK = 1'b1,
    parameter int DEPTH       = 16,
    parameter int FILL_W      = 5,
    parameter int COUNT_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [FILL_W-1:0]      fill,
    input  logic                   empty,
    input  logic                   full,
    input  logic                   enable,
    input  logic [ATTN_CODE_W-1:0] lvl_code,
    input  logic                   err_evt,
    input  logic                   err_w1c,
    output logic [COUNT_W-1:0]     slot_count,
    output logic                   attn,
    output logic                   ready,
    output logic                   busy,
    output logic                   error
);
    logic [COUNT_W-1:0] thresh;
    logic               err_q;

    // Turn the threshold code into a slot count.
    always_comb begin
        case (attn_code_e'(lvl_code))
            ATTN_ONE:   thresh = COUNT_W'(SLOTS_ONE);
            ATTN_FOUR:  thresh = COUNT_W'(SLOTS_FOUR);
            ATTN_EIGHT: thresh = COUNT_W'(SLOTS_EIGHT);
            default:    thresh = COUNT_W'(SLOTS_TWELVE);
        endcase
    end

    generate
        if (IS_PLAYBACK) begin : g_free
            assign slot_count = COUNT_W'(DEPTH) - COUNT_W'(fill);
            assign ready      = ~full;
        end else begin : g_used
            logic unused_full;
            assign unused_full = full;
            assign slot_count  = COUNT_W'(fill);
            assign ready       = ~empty;
        end
    endgenerate

    assign attn = (slot_count >= thresh);
    assign busy = enable & ~empty;

    // Set the error flag on an event and hold it until write-one-to-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_q <= 1'b0;
        end else if (err_evt) begin
            err_q <= 1'b1;
        end else if (err_w1c) begin
            err_q <= 1'b0;
        end
    end

    assign error = err_q;
endmodule

// File: rtl/audio_svc_fifo.sv
// Audio service FIFO top. IS_PLAYBACK selects the direction. In playback the
// bus pushes and the serial engine pops. In capture the serial engine pushes
// and the bus pops.
// Assumes: one clock domain. The serial side acts only while enable is high.
// Clear overrides every transfer in its cycle.
module audio_svc_fifo
    import audio_fifo_pkg::*;
#(
    parameter bit IS_PLAYBACK = 1'b1,
    parameter int WIDTH       = 32,
    parameter int DEPTH       = 16,
    parameter int COUNT_W     = 6
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   enable,
    input  logic                   clear,
    input  logic                   packed_mode,
    input  logic [ATTN_CODE_W-1:0] lvl_code,
    input  logic                   err_w1c,
    input  logic                   bus_wr_en,
    input  logic [WIDTH-1:0]       bus_wr_data,
    input  logic                   bus_rd_en,
    output logic [WIDTH-1:0]       bus_rd_data,
    input  logic                   ser_req,
    input  logic [WIDTH-1:0]       ser_wdata,
    output logic [WIDTH-1:0]       ser_rdata,
    output logic [COUNT_W-1:0]     slot_count,
    output logic                   attn,
    output logic                   ready,
    output logic                   busy,
    output logic                   error
);
    localparam int FILL_W = $clog2(DEPTH + 1);

    logic              push;
    logic              pop;
    logic [WIDTH-1:0]  push_data;
    logic [WIDTH-1:0]  head_data;
    logic [FILL_W-1:0] fill;
    logic              empty;
    logic              full;
    logic              ser_go;
    logic              step;
    logic              boundary;
    logic [WIDTH-1:0]  rd_sample;
    logic [WIDTH-1:0]  wr_word;
    logic              err_evt;

    assign ser_go = enable & ser_req & ~clear;

    generate
        if (IS_PLAYBACK) begin : g_play
            // Bus fills the FIFO; the serial engine drains it one sample at a time.
            logic unused_play;
            assign unused_play = ^{bus_rd_en, wr_word};
            assign push        = bus_wr_en & ~full & ~clear;
            assign push_data   = bus_wr_data;
            assign step        = ser_go & ~empty;
            assign pop         = step & boundary;
            assign err_evt     = ser_go & empty;
            assign ser_rdata   = rd_sample;
            assign bus_rd_data = '0;
        end else begin : g_capt
            // The serial engine fills the FIFO; the bus drains whole entries.
            logic unused_capt;
            assign unused_capt = ^{bus_wr_en, bus_wr_data, rd_sample};
            assign step        = ser_go;
            assign push        = ser_go & boundary & ~full;
            assign push_data   = wr_word;
            assign err_evt     = ser_go & boundary & full;
            assign pop         = bus_rd_en & ~empty & ~clear;
            assign bus_rd_data = empty ? '0 : head_data;
            assign ser_rdata   = '0;
        end
    endgenerate

    afifo_store #(
        .WIDTH (WIDTH),
        .DEPTH (DEPTH)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (clear),
        .push      (push),
        .push_data (push_data),
        .pop       (pop),
        .head_data (head_data),
        .fill      (fill),
        .empty     (empty),
        .full      (full)
    );

    afifo_halfsel #(
        .WIDTH (WIDTH)
    ) u_halfsel (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (clear),
        .packed_mode (packed_mode),
        .step        (step),
        .ser_wdata   (ser_wdata),
        .head_data   (head_data),
        .empty       (empty),
        .boundary    (boundary),
        .rd_sample   (rd_sample),
        .wr_word     (wr_word)
    );

    afifo_status #(
        .IS_PLAYBACK (IS_PLAYBACK),
        .DEPTH       (DEPTH),
        .FILL_W      (FILL_W),
        .COUNT_W     (COUNT_W)
    ) u_status (
        .clk        (clk),
        .rst_n      (rst_n),
        .fill       (fill),
        .empty      (empty),
        .full       (full),
        .enable     (enable),
        .lvl_code   (lvl_code),
        .err_evt    (err_evt),
        .err_w1c    (err_w1c),
        .slot_count (slot_count),
        .attn       (attn),
        .ready      (ready),
        .busy       (busy),
        .error      (error)
    );
endmodule

// File: rtl/audio_svc_fifo_chk.sv
// Property checker for the audio service FIFO, bound to every instance.
// Assumes: it sees only the top-level ports of the instance it is bound to.
module audio_svc_fifo_chk #(
    parameter bit IS_PLAYBACK = 1'b1,
    parameter int DEPTH       = 16,
    parameter int COUNT_W     = 6
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enable,
    input logic               clear,
    input logic               err_w1c,
    input logic               bus_wr_en,
    input logic               bus_rd_en,
    input logic [COUNT_W-1:0] slot_count,
    input logic               ready,
    input logic               busy,
    input logic               error
);
    localparam logic [COUNT_W-1:0] EMPTY_COUNT = IS_PLAYBACK ? COUNT_W'(DEPTH) : '0;

    // R3
    count_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_count <= COUNT_W'(DEPTH));

    // R10
    clear_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> (slot_count == EMPTY_COUNT));

    // R8
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (error && !err_w1c) |=> error);

    // R9
    err_w1c_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_w1c && !enable) |=> !error);

    // R7
    disabled_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!enable && !clear && !bus_wr_en && !bus_rd_en) |=> $stable(slot_count));

    // R5
    ready_slots_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ready == (slot_count != '0));

    // R6
    busy_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> enable);
endmodule

bind audio_svc_fifo audio_svc_fifo_chk #(
    .IS_PLAYBACK (IS_PLAYBACK),
    .DEPTH       (DEPTH),
    .COUNT_W     (COUNT_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .clear      (clear),
    .err_w1c    (err_w1c),
    .bus_wr_en  (bus_wr_en),
    .bus_rd_en  (bus_rd_en),
    .slot_count (slot_count),
    .ready      (ready),
    .busy       (busy),
    .error      (error)
);

// File: tb/tb_audio_svc_fifo.sv
// Bench: a playback copy (dut) and a capture copy (dut_cap) share the same
// stimulus. Queue models hold the expected contents. Directed corners run
// first, then random traffic with a fixed seed.
module tb_audio_svc_fifo;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable, clear, packed_mode, err_w1c;
    logic [1:0]  lvl_code;
    logic        bus_wr_en, bus_rd_en, ser_req;
    logic [31:0] bus_wr_data, ser_wdata;

    logic [31:0] p_bus_rd_data, p_ser_rdata, c_bus_rd_data, c_ser_rdata;
    logic [5:0]  p_cnt, c_cnt;
    logic        p_attn, p_ready, p_busy, p_err;
    logic        c_attn, c_ready, c_busy, c_err;

    int n_chk = 0;
    int n_err = 0;

    logic [31:0] pq[$];
    logic [31:0] cq[$];
    bit          p_half, c_half, pm_err, cm_err;
    logic [15:0] c_stage;

    always #5 clk = ~clk;

    audio_svc_fifo #(.IS_PLAYBACK(1'b1)) dut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
        .packed_mode(packed_mode), .lvl_code(lvl_code), .err_w1c(err_w1c),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
        .bus_rd_data(p_bus_rd_data), .ser_req(ser_req), .ser_wdata(ser_wdata),
        .ser_rdata(p_ser_rdata), .slot_count(p_cnt), .attn(p_attn),
        .ready(p_ready), .busy(p_busy), .error(p_err));

    audio_svc_fifo #(.IS_PLAYBACK(1'b0)) dut_cap (
        .clk(clk), .rst_n(rst_n), .enable(enable), .clear(clear),
        .packed_mode(packed_mode), .lvl_code(lvl_code), .err_w1c(err_w1c),
        .bus_wr_en(bus_wr_en), .bus_wr_data(bus_wr_data), .bus_rd_en(bus_rd_en),
        .bus_rd_data(c_bus_rd_data), .ser_req(ser_req), .ser_wdata(ser_wdata),
        .ser_rdata(c_ser_rdata), .slot_count(c_cnt), .attn(c_attn),
        .ready(c_ready), .busy(c_busy), .error(c_err));

    function automatic int thr(input logic [1:0] code);
        case (code)
            2'd0:    return 1;
            2'd1:    return 4;
            2'd2:    return 8;
            default: return 12;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    endtask

    task automatic post_checks(input string cnt_tag, input string err_tag,
                               input bit en, input logic [1:0] lvl);
        int pf;
        int cf;
        pf = 16 - pq.size();
        cf = cq.size();
        chk(cnt_tag, "pb slot_count", 32'(p_cnt), 32'(pf));
        chk("R4", "pb attn", 32'(p_attn), 32'(pf >= thr(lvl)));
        chk("R5", "pb ready", 32'(p_ready), 32'(pq.size() < 16));
        chk("R6", "pb busy", 32'(p_busy), 32'(en && pq.size() != 0));
        chk(err_tag, "pb error", 32'(p_err), 32'(pm_err));
        chk(cnt_tag, "cap slot_count", 32'(c_cnt), 32'(cf));
        chk("R4", "cap attn", 32'(c_attn), 32'(cf >= thr(lvl)));
        chk("R5", "cap ready", 32'(c_ready), 32'(cq.size() > 0));
        chk("R6", "cap busy", 32'(c_busy), 32'(en && cq.size() != 0));
        chk(err_tag, "cap error", 32'(c_err), 32'(cm_err));
    endtask

    // One cycle: drive, check the head outputs, update the models, check status.
    task automatic tick(input bit en, input bit clr, input bit pk, input bit w1c,
                        input bit bw, input bit br, input bit sr,
                        input logic [1:0] lvl, input logic [31:0] bwd,
                        input logic [31:0] swd);
        logic [31:0] h;
        logic [31:0] ep;
        logic [31:0] cw;
        bit go, p_ev, c_ev, p_pop, c_push, p_empty, p_full, c_empty, c_full;
        string cnt_tag;
        enable = en; clear = clr; packed_mode = pk; err_w1c = w1c;
        bus_wr_en = bw; bus_rd_en = br; ser_req = sr; lvl_code = lvl;
        bus_wr_data = bwd; ser_wdata = swd;
        #1;
        p_empty = (pq.size() == 0);
        p_full  = (pq.size() == 16);
        c_empty = (cq.size() == 0);
        c_full  = (cq.size() == 16);
        h  = p_empty ? 32'h0 : pq[0];
        ep = p_empty ? 32'h0 : (!pk ? h : (p_half ? {16'h0, h[31:16]} : {16'h0, h[15:0]}));
        chk(p_empty ? "R13" : (pk ? "R11" : "R2"), "pb ser_rdata", p_ser_rdata, ep);
        h = c_empty ? 32'h0 : cq[0];
        chk(c_empty ? "R13" : (pk ? "R12" : "R2"), "cap bus_rd_data", c_bus_rd_data, h);

        go = en && sr && !clr;
        p_ev = 0; c_ev = 0; p_pop = 0; c_push = 0; cw = 32'h0;
        if (clr) begin
            pq.delete(); cq.delete();
            p_half = 0; c_half = 0; c_stage = 16'h0;
        end else begin
            if (go) begin
                if (p_empty) p_ev = 1;
                else begin
                    if (!pk || p_half) p_pop = 1;
                    p_half = pk && !p_half;
                end
                if (!pk || c_half) begin
                    if (c_full) c_ev = 1;
                    else begin
                        c_push = 1;
                        cw = pk ? {swd[15:0], c_stage} : swd;
                    end
                end
                if (pk && !c_half) c_stage = swd[15:0];
                c_half = pk && !c_half;
            end
            if (bw && !p_full) pq.push_back(bwd);
            if (p_pop) void'(pq.pop_front());
            if (br && !c_empty) void'(cq.pop_front());
            if (c_push) cq.push_back(cw);
        end
        if (p_ev) pm_err = 1; else if (w1c) pm_err = 0;
        if (c_ev) cm_err = 1; else if (w1c) cm_err = 0;

        @(posedge clk);
        #1;
        cnt_tag = clr ? "R10" : (!en ? "R7" : "R3");
        post_checks(cnt_tag, w1c ? "R9" : "R8", en, lvl);
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog R2: actual=timeout expected=finish");
        summary();
        $finish;
    end

    initial begin
        void'($urandom(32'd7319));
        rst_n = 1'b0; enable = 0; clear = 0; packed_mode = 0; err_w1c = 0;
        lvl_code = 2'd0; bus_wr_en = 0; bus_rd_en = 0; ser_req = 0;
        bus_wr_data = 32'h0; ser_wdata = 32'h0;
        p_half = 0; c_half = 0; c_stage = 16'h0; pm_err = 0; cm_err = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state of both copies
        chk("R1", "pb slot_count", 32'(p_cnt), 32'd16);
        chk("R1", "pb attn", 32'(p_attn), 32'd1);
        chk("R1", "pb ready", 32'(p_ready), 32'd1);
        chk("R1", "pb busy/error", 32'({p_busy, p_err}), 32'd0);
        chk("R1", "pb ser_rdata", p_ser_rdata, 32'h0);
        chk("R1", "cap slot_count", 32'(c_cnt), 32'd0);
        chk("R1", "cap attn/ready", 32'({c_attn, c_ready}), 32'd0);
        chk("R1", "cap busy/error", 32'({c_busy, c_err}), 32'd0);
        chk("R1", "cap bus_rd_data", c_bus_rd_data, 32'h0);

        // R7 fill playback with the serial side disabled; the 17th write is dropped (R2)
        for (int i = 0; i < 17; i++)
            tick(0, 0, 0, 0, 1, 0, 1, 2'd1, 32'hA500_0000 + 32'(i), 32'h5A5A_0000 + 32'(i));
        // R2 drain in order; the final request underruns (R8)
        for (int i = 0; i < 17; i++)
            tick(1, 0, 0, 0, 0, 0, 1, 2'd2, 32'h0, 32'hC000_0000 + 32'(i));
        // R9 err_w1c together with a fresh underrun keeps error set, then clears it
        tick(1, 0, 0, 1, 0, 0, 1, 2'd3, 32'h0, 32'h1111_2222);
        tick(1, 0, 0, 1, 0, 0, 0, 2'd3, 32'h0, 32'h0);
        // Capture fills to 16 above; one more serial write overruns (R8)
        tick(1, 0, 0, 0, 0, 0, 1, 2'd3, 32'h0, 32'hDEAD_BEEF);
        // R10 clear against a bus write, a serial request and a bus read
        for (int i = 0; i < 3; i++)
            tick(0, 0, 0, 0, 1, 0, 0, 2'd0, 32'h0BAD_0000 + 32'(i), 32'h0);
        tick(1, 1, 0, 0, 1, 1, 1, 2'd0, 32'hFFFF_FFFF, 32'hEEEE_EEEE);
        tick(1, 0, 0, 1, 0, 0, 0, 2'd0, 32'h0, 32'h0);
        // R11 / R12 packed halves in both directions
        tick(1, 1, 1, 0, 0, 0, 0, 2'd0, 32'h0, 32'h0);
        tick(1, 0, 1, 0, 1, 0, 0, 2'd0, 32'h2222_1111, 32'h0);
        tick(1, 0, 1, 0, 1, 0, 0, 2'd0, 32'h4444_3333, 32'h0);
        for (int i = 0; i < 6; i++)
            tick(1, 0, 1, 0, 0, 0, 1, 2'd0, 32'h0, 32'hF000_0A00 + 32'(i));
        for (int i = 0; i < 4; i++)
            tick(1, 0, 1, 0, 0, 1, 0, 2'd0, 32'h0, 32'h0);
        tick(1, 0, 1, 1, 0, 0, 0, 2'd0, 32'h0, 32'h0);

        // Random phases: packing, write bias, bus-read bias, serial bias
        for (int ph = 0; ph < 4; ph++) begin
            bit   pk;
            int   wb, rb, sb;
            logic [1:0] lvl;
            pk = (ph >= 2);
            wb = (ph % 2 == 0) ? 70 : 30;
            rb = (ph % 2 == 0) ? 30 : 70;
            sb = (ph % 2 == 0) ? 45 : 65;
            lvl = 2'd0;
            tick(1, 1, pk, 1, 0, 0, 0, lvl, 32'h0, 32'h0);
            for (int i = 0; i < 2500; i++) begin
                if (i % 50 == 0) lvl = 2'($urandom_range(0, 3));
                tick($urandom_range(0, 9) != 0, $urandom_range(0, 59) == 0, pk,
                     $urandom_range(0, 19) == 0, $urandom_range(0, 99) < wb,
                     $urandom_range(0, 99) < rb, $urandom_range(0, 99) < sb,
                     lvl, $urandom, $urandom);
            end
        end

        summary();
        $finish;
    end
endmodule